// File: doc/BRIEF.md
# Degree-Four Scaled Min-Sum Variable Node

This block is the variable-node arithmetic of a column-oriented min-sum LDPC decoder for columns with four check-node neighbours. In each cycle it takes four check-to-variable messages in sign-magnitude form and a signed channel value. For every edge it returns a variable-to-check message. That message is the channel value plus three quarters of the sum of the other three incoming messages, clamped to the message range. The block also returns a hard-decision bit for the bit position.

The datapath never negates an operand in full two's complement. A negative magnitude enters the sum as its bitwise complement. The missing +1 of every such operand is collected as a small count of sign bits, and that count joins the sum in the second carry-save stage. Three-operand stages are carry-save compressors followed by one carry-propagate adder. The 0.75 factor is the sum of two arithmetic right shifts. An optional output register, enabled by default, gives one cycle of latency. Message storage, shifting networks and check-node logic live elsewhere.

Top module: `vnu_core`

## Requirements
- R1: With OUT_REG=1, an active-low `rst_n` clears `v2c_o` and `hard_o` to zero at once and keeps them at zero while it is held, whatever the inputs are. Results then appear on the outputs on the second clock edge after reset.
- R2: Edge k of `v2c_o` (bits 4k+3..4k) carries the saturated value of fl(S/2) + fl(S/4) + I. Here S is the signed sum of the three messages other than message k, I is the intrinsic value, and fl rounds toward minus infinity.
- R3: Each input message is 4 bits wide. Bit 3 is the sign (1 means negative) and bits 2..0 are the magnitude. A message with sign 1 and magnitude 0 counts as zero.
- R4: The scaling rounds each of the two shifted terms toward minus infinity on its own. For example, S = -1 with I = 0 gives -2.
- R5: Results above +7 become +7 and results below -7 become -7.
- R6: Outputs use the same sign-magnitude encoding as the inputs, and a zero result is always sent with sign bit 0.
- R7: `intr_i` is a 4-bit two's complement value (-8..7), and -8 is accepted and used as is.
- R8: `hard_o` is 1 exactly when fl(T/2) + fl(T/4) + I < 0, where T is the signed sum of all four input messages.
- R9: With OUT_REG=1, both outputs show the result of the inputs sampled at the previous rising edge. Message k has no effect on output edge k.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the optional output register |
| rst_n | input | 1 | Asynchronous active-low reset of the output register |
| c2v_i | input | 16 | Four sign-magnitude check-to-variable messages, message k in bits 4k+3..4k |
| intr_i | input | 4 | Intrinsic channel value, two's complement |
| v2c_o | output | 16 | Four sign-magnitude variable-to-check messages, edge k in bits 4k+3..4k |
| hard_o | output | 1 | Hard decision, 1 for a negative posterior |

## Verification
Uniform random messages seldom produce the inputs that expose the correction-count path. Those inputs are a set of negative messages that sum to a small odd negative value, so that both shifts round down, and negative zeros mixed with real negatives. The stimulus therefore adds directed vectors for these cases and biases part of the random stream toward small magnitudes with the sign bit set. Saturation at both rails and the -8 intrinsic also get directed vectors. Independence from a message's own edge is checked by changing only that message and comparing the edge output across the two cycles.

// File: rtl/vnu_pkg.sv
package vnu_pkg;
    localparam int DEG   = 4;            // column degree, structure below is built for four
    localparam int MW    = 3;            // magnitude bits of one message
    localparam int MSG_W = MW + 1;       // sign plus magnitude
    localparam int IW    = 4;            // intrinsic width, two's complement
    localparam int AW    = MW + 5;       // accumulator width with headroom for four terms
    localparam int SSW   = $clog2(DEG);  // sign count of three operands
    localparam int SSW4  = $clog2(DEG + 1);
    localparam int SMAX  = (1 << MW) - 1;

    localparam logic signed [AW-1:0] POS_LIM = AW'(SMAX);
    localparam logic signed [AW-1:0] NEG_LIM = -POS_LIM;

    typedef struct packed {
        logic [DEG-1:0][MSG_W-1:0] v2c;
        logic                      hard;
    } vnu_out_t;

    // signed value of a sign-magnitude message
    function automatic logic signed [AW-1:0] sm_val(input logic [MSG_W-1:0] m);
        logic signed [AW-1:0] mag;
        mag = AW'(m[MW-1:0]);
        return m[MW] ? -mag : mag;
    endfunction

    // clamp and re-encode as sign-magnitude, zero always positive
    function automatic logic [MSG_W-1:0] to_sm(input logic signed [AW-1:0] v);
        logic signed [AW-1:0] neg;
        neg = -v;
        if (v > POS_LIM)      return {1'b0, MW'(SMAX)};
        else if (v < NEG_LIM) return {1'b1, MW'(SMAX)};
        else if (v < 0)       return {1'b1, MW'(neg)};
        else                  return {1'b0, MW'(v)};
    endfunction
endpackage

// File: rtl/vnu_fold.sv
module vnu_fold
    import vnu_pkg::*;
(
    input  logic [MSG_W-1:0] msg_i,
    output logic [AW-1:0]    term_o,
    output logic             sgn_o
);
    // negative magnitudes enter as their complement; the +1 is counted elsewhere
    assign sgn_o  = msg_i[MW];
    assign term_o = msg_i[MW] ? ~AW'(msg_i[MW-1:0]) : AW'(msg_i[MW-1:0]);
endmodule

// File: rtl/vnu_csa3.sv
module vnu_csa3 #(
    parameter int W = 8
) (
    input  logic [W-1:0] a_i,
    input  logic [W-1:0] b_i,
    input  logic [W-1:0] c_i,
    output logic [W-1:0] s_o,
    output logic [W-1:0] k_o
);
    assign s_o = a_i ^ b_i ^ c_i;
    assign k_o = {(a_i[W-2:0] & b_i[W-2:0]) | (a_i[W-2:0] & c_i[W-2:0])
                  | (b_i[W-2:0] & c_i[W-2:0]), 1'b0};
endmodule

// File: rtl/vnu_scale.sv
module vnu_scale
    import vnu_pkg::*;
(
    input  logic [AW-1:0] sum_i,
    input  logic [IW-1:0] intr_i,
    output logic [AW-1:0] res_o
);
    logic [AW-1:0] half, quarter, intr_ext, s3, k3;

    assign half     = AW'($signed(sum_i) >>> 1);
    assign quarter  = AW'($signed(sum_i) >>> 2);
    assign intr_ext = {{(AW-IW){intr_i[IW-1]}}, intr_i};

    vnu_csa3 #(.W(AW)) u_csa (
        .a_i(half), .b_i(quarter), .c_i(intr_ext), .s_o(s3), .k_o(k3)
    );

    assign res_o = s3 + k3;
endmodule

// File: rtl/vnu_core.sv
module vnu_core
    import vnu_pkg::*;
#(
    parameter bit OUT_REG = 1'b1
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [DEG*MSG_W-1:0]   c2v_i,
    input  logic [IW-1:0]          intr_i,
    output logic [DEG*MSG_W-1:0]   v2c_o,
    output logic                   hard_o
);
    logic [AW-1:0]    term [DEG];
    logic [DEG-1:0]   sgn;
    logic [MSG_W-1:0] edge_msg [DEG];
    logic [AW-1:0]    hres;
    vnu_out_t         out_d;
    logic             no_mag;

    // sign folding of every incoming message
    for (genvar k = 0; k < DEG; k++) begin : g_fold
        vnu_fold u_fold (
            .msg_i (c2v_i[k*MSG_W +: MSG_W]),
            .term_o(term[k]),
            .sgn_o (sgn[k])
        );
    end

    // one extrinsic datapath per edge
    for (genvar k = 0; k < DEG; k++) begin : g_edge
        localparam int A = (k + 1) % DEG;
        localparam int B = (k + 2) % DEG;
        localparam int C = (k + 3) % DEG;
        logic [SSW-1:0] ssum;
        logic [AW-1:0]  s1, k1, s2, k2, tot, res;

        assign ssum = SSW'(sgn[A]) + SSW'(sgn[B]) + SSW'(sgn[C]);

        vnu_csa3 #(.W(AW)) u_c1 (
            .a_i(term[A]), .b_i(term[B]), .c_i(term[C]), .s_o(s1), .k_o(k1)
        );
        vnu_csa3 #(.W(AW)) u_c2 (
            .a_i(s1), .b_i(k1), .c_i(AW'(ssum)), .s_o(s2), .k_o(k2)
        );
        assign tot = s2 + k2;

        vnu_scale u_scale (.sum_i(tot), .intr_i(intr_i), .res_o(res));
        assign edge_msg[k] = to_sm(res);

        // R2: carry-save path agrees with a plain signed sum of the three messages
        always_comb begin
            if (rst_n) begin
                p_csa_sum_r2: assert ($signed(tot) == sm_val(c2v_i[A*MSG_W +: MSG_W])
                                      + sm_val(c2v_i[B*MSG_W +: MSG_W])
                                      + sm_val(c2v_i[C*MSG_W +: MSG_W]))
                    else $error("edge %0d carry-save sum mismatch", k);
            end
        end
    end

    // posterior sum over all four messages for the hard decision
    logic [SSW4-1:0] ssum4;
    logic [AW-1:0]   ha_s, ha_k, hb_s, hb_k, hc_s, hc_k, htot;

    assign ssum4 = SSW4'(sgn[0]) + SSW4'(sgn[1]) + SSW4'(sgn[2]) + SSW4'(sgn[3]);

    vnu_csa3 #(.W(AW)) u_h1 (
        .a_i(term[0]), .b_i(term[1]), .c_i(term[2]), .s_o(ha_s), .k_o(ha_k)
    );
    vnu_csa3 #(.W(AW)) u_h2 (
        .a_i(ha_s), .b_i(ha_k), .c_i(term[3]), .s_o(hb_s), .k_o(hb_k)
    );
    vnu_csa3 #(.W(AW)) u_h3 (
        .a_i(hb_s), .b_i(hb_k), .c_i(AW'(ssum4)), .s_o(hc_s), .k_o(hc_k)
    );
    assign htot = hc_s + hc_k;

    vnu_scale u_hscale (.sum_i(htot), .intr_i(intr_i), .res_o(hres));

    always_comb begin
        out_d.hard = ($signed(hres) < 0);
        for (int k = 0; k < DEG; k++) out_d.v2c[k] = edge_msg[k];
        no_mag = 1'b1;
        for (int k = 0; k < DEG; k++)
            if (c2v_i[k*MSG_W +: MW] != '0) no_mag = 1'b0;
    end

    if (OUT_REG) begin : g_reg
        vnu_out_t out_q;

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) out_q <= '0;
            else        out_q <= out_d;
        end

        assign v2c_o  = out_q.v2c;
        assign hard_o = out_q.hard;

        for (genvar k = 0; k < DEG; k++) begin : g_chk
            // R6: a set sign bit never comes with a zero magnitude
            p_zero_pos_r6: assert property (@(posedge clk) disable iff (!rst_n)
                v2c_o[k*MSG_W + MW] |-> (v2c_o[k*MSG_W +: MW] != '0))
                else $error("negative zero on edge %0d", k);

            // R5: with no message weight each edge is the clamped intrinsic
            p_intr_only_r5: assert property (@(posedge clk) disable iff (!rst_n)
                no_mag |=> (v2c_o[k*MSG_W +: MSG_W]
                            == to_sm(AW'($signed($past(intr_i))))))
                else $error("edge %0d not equal to clamped intrinsic", k);
        end

        // R8: all-nonnegative inputs never give a negative decision
        p_hard_pos_r8: assert property (@(posedge clk) disable iff (!rst_n)
            ((sgn == '0) && !intr_i[IW-1]) |=> !hard_o)
            else $error("hard decision negative for nonnegative inputs");
    end else begin : g_comb
        assign v2c_o  = out_d.v2c;
        assign hard_o = out_d.hard;
    end
endmodule

// File: tb/vnu_core_bench.sv
module vnu_core_bench;
    logic        clk = 1'b0;
    logic        rst_n;
    logic [15:0] c2v;
    logic [3:0]  intr;
    logic [15:0] v2c;
    logic        hard;
    int          n_run  = 0;
    int          n_fail = 0;
    bit          done   = 1'b0;

    always #10 clk = ~clk;

    vnu_core u_vnu_core (
        .clk(clk), .rst_n(rst_n), .c2v_i(c2v), .intr_i(intr),
        .v2c_o(v2c), .hard_o(hard)
    );

    function automatic int sm2i(input logic [3:0] m);
        return m[3] ? -int'(m[2:0]) : int'(m[2:0]);
    endfunction

    function automatic int scl(input int s);
        return (s >>> 1) + (s >>> 2);
    endfunction

    function automatic logic [3:0] enc(input int v);
        if (v > 7)  return 4'b0111;
        if (v < -7) return 4'b1111;
        if (v < 0)  return {1'b1, 3'(-v)};
        return {1'b0, 3'(v)};
    endfunction

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // drive, let one rising edge register the result, compare at the next falling edge
    task automatic apply(input logic [15:0] c, input logic [3:0] i, input string tag);
        int tot;
        int iv;
        logic [15:0] e;
        @(negedge clk);
        c2v = c; intr = i;
        @(negedge clk);
        iv  = int'($signed(i));
        tot = 0;
        for (int j = 0; j < 4; j++) tot += sm2i(c[j*4 +: 4]);
        for (int k = 0; k < 4; k++)
            e[k*4 +: 4] = enc(scl(tot - sm2i(c[k*4 +: 4])) + iv);
        chk({tag, " R2 edges"}, v2c, e);
        chk({tag, " R8 hard"}, {15'd0, hard}, {15'd0, (scl(tot) + iv) < 0});
    endtask

    initial begin
        #(20 * 150000);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        logic [15:0] rc;
        logic [3:0]  held;
        void'($urandom(32'd20240611));
        rst_n = 1'b0; c2v = 16'h7777; intr = 4'd5;
        repeat (3) @(negedge clk);
        // R1: held in reset despite nonzero inputs
        chk("R1 reset v2c", v2c, 16'h0000);
        chk("R1 reset hard", {15'd0, hard}, 16'h0000);
        rst_n = 1'b1;

        // R7/R5: zero messages, most negative intrinsic clamps to -7
        apply(16'h0000, 4'b1000, "R7 R5 intr-8");
        chk("R7 literal", v2c, 16'hFFFF);
        // R5: positive rail
        apply(16'h7777, 4'd7, "R5 pos sat");
        chk("R5 literal", v2c, 16'h7777);
        // R5: negative rail
        apply(16'hFFFF, 4'b1001, "R5 neg sat");
        // R4: S=-1 on edge 0 gives -2 -> 4'b1010
        apply(16'h0090, 4'd0, "R4 floor");
        chk("R4 literal edge0", {12'd0, v2c[3:0]}, 16'h000A);
        // R3: negative zeros count as zero
        apply(16'h8888, 4'd3, "R3 negzero");
        chk("R3 literal", v2c, 16'h3333);
        // R6: result exactly zero is positive
        apply(16'h0002, 4'b1111, "R6 zero pos");
        // R3/R4: mixed negative zeros with small negatives
        apply(16'h9A8B, 4'd1, "R3 mix");
        apply(16'hB9A9, 4'd0, "R4 odd neg");

        // R9: change only message 0, edge 0 output must not move
        apply(16'h3A52, 4'd2, "R9 base");
        held = v2c[3:0];
        apply(16'h3A5F, 4'd2, "R9 own");
        chk("R9 own-input edge0", {12'd0, v2c[3:0]}, {12'd0, held});

        // R9: latency, result not visible before the rising edge
        @(negedge clk); c2v = 16'h7777; intr = 4'd7;
        @(negedge clk); c2v = 16'h0000; intr = 4'd0;
        #5;
        chk("R9 latency hold", v2c, 16'h7777);

        // random mix, every fourth vector biased to small negatives
        for (int n = 0; n < 3000; n++) begin
            rc = 16'($urandom);
            if (n % 4 == 0) rc = rc & 16'h9999 | 16'h8888;
            apply(rc, 4'($urandom), "rand");
        end

        // R1: asynchronous reset mid-run
        @(negedge clk); c2v = 16'h1234; intr = 4'd6;
        @(negedge clk); rst_n = 1'b0;
        #2;
        chk("R1 async v2c", v2c, 16'h0000);
        chk("R1 async hard", {15'd0, hard}, 16'h0000);
        @(negedge clk); rst_n = 1'b1;

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule